// File: doc/BRIEF.md
# Paged Processor Address Extension Unit

This block lets a processor with a 27-bit byte address reach a 32-bit system address space. The processor issues doubleword-aligned accesses, so it presents only the upper 24 bits of its byte address. The top three of those bits pick one of eight page registers. Each page register covers 16 MB and holds an 8-bit base value and a small attribute field. The base value replaces the top byte of the address. The lower offset bits pass through unchanged, and the three byte-select bits come out as zero.

Processor traffic may only land in the lower 2 GB of the 4 GB space, because the upper half belongs to other on-chip cores. If a page register holds a base that points into the upper half, the unit clears the top address bit and sets a sticky error flag. A write port loads the page registers. Each translated access is steered either to the external memory controller or to the on-chip bus. The steering depends on whether the translated top byte falls inside a parameterised memory window.

Top module: `pae_addr_ext`

## Requirements
- R1: After reset, out_valid and err_flag are 0, and page register k holds base k with attribute 0, so page k maps onto itself (identity mapping).
- R2: A request sampled with req_valid high produces out_valid high on the next clock edge, with out_write equal to the sampled req_write. A request with req_valid low produces out_valid low on the next edge.
- R3: On a translated access, out_addr[2:0] is 0 and out_addr[23:3] equals req_addr[20:0].
- R4: req_addr[23:21] selects the page register, and out_addr[30:24] equals bits 6:0 of that register's base.
- R5: out_addr[31] is always 0. A request whose selected base has bit 7 set raises err_flag on the same edge as its output. err_flag then stays set until reset.
- R6: A page register write on cfg_we affects requests from the following cycle onward. A request in the same cycle as the write uses the old contents.
- R7: out_to_mem is 1 exactly when out_addr[31:24] lies within MEM_LO..MEM_HI (defaults 0x00 and 0x3F). Otherwise it is 0, which selects the on-chip bus.
- R8: out_attr equals the attribute field of the page register used by the access.
- R9: While req_valid is low, out_addr, out_to_mem, out_attr and out_write keep the values of the last translated access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Page register write strobe |
| cfg_idx | input | 3 | Page register being written |
| cfg_base | input | 8 | Base value to write |
| cfg_attr | input | 2 | Attribute value to write |
| req_valid | input | 1 | Processor access request |
| req_write | input | 1 | Access is a write |
| req_addr | input | 24 | Processor doubleword address (byte address bits 26:3) |
| out_valid | output | 1 | Translated access valid |
| out_write | output | 1 | Translated access is a write |
| out_addr | output | 32 | Translated system byte address |
| out_to_mem | output | 1 | 1: external memory controller, 0: on-chip bus |
| out_attr | output | 2 | Attribute of the page used |
| err_flag | output | 1 | Sticky flag for an upper-half base value |

## Verification
The bench sweeps all eight pages straight after reset. A design that did not reset to the identity mapping, or that decoded the page field from the wrong bits, would return wrong top bytes there. It writes a page register and issues a request to that page in the same cycle. An implementation that forwarded the new value a cycle early would return the new base instead of the old one. It loads a base with bit 7 set. A design that let the upper half through would show bit 31 high, and one that failed to hold the error would drop err_flag on later clean accesses. Idle gaps and a base outside the memory window catch outputs that drift without a request and steering that ignores the window bounds.

// File: rtl/pae_pkg.sv
package pae_pkg;
  localparam int BASE_W = 8;
  localparam int ATTR_W = 2;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [ATTR_W-1:0] attr;
  } page_entry_t;
endpackage

// File: rtl/pae_page_regs.sv
module pae_page_regs
  import pae_pkg::*;
#(
  parameter int PAGE_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [PAGE_BITS-1:0] wr_idx,
  input  logic [BASE_W-1:0]    wr_base,
  input  logic [ATTR_W-1:0]    wr_attr,
  input  logic [PAGE_BITS-1:0] rd_idx,
  output page_entry_t          rd_entry
);
  localparam int NUM_PAGES = 1 << PAGE_BITS;

  page_entry_t pages_q [NUM_PAGES];

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    page_entry_t nxt;
    logic        en;

    always_comb begin
      en       = wr_en && (wr_idx == PAGE_BITS'(g));
      nxt.base = wr_base;
      nxt.attr = wr_attr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pages_q[g].base <= BASE_W'(g);
        pages_q[g].attr <= '0;
      end else if (en) begin
        pages_q[g] <= nxt;
      end
    end
  end

  assign rd_entry = pages_q[rd_idx];

  assert_cfg_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pages_q[$past(wr_idx)].base == $past(wr_base)));
endmodule

// File: rtl/pae_xlate.sv
module pae_xlate
  import pae_pkg::*;
#(
  parameter int                ADDR_IN_W = 24,
  parameter int                OUT_W     = 32,
  parameter int                PAGE_BITS = 3,
  parameter logic [BASE_W-1:0] MEM_LO    = 8'h00,
  parameter logic [BASE_W-1:0] MEM_HI    = 8'h3F
) (
  input  logic [ADDR_IN_W-1:0] req_addr,
  input  page_entry_t          entry,
  output logic [OUT_W-1:0]     xaddr,
  output logic                 to_mem,
  output logic                 base_bad
);
  localparam int OFFSET_W = ADDR_IN_W - PAGE_BITS;
  localparam int LSB_W    = OUT_W - BASE_W - OFFSET_W;
  localparam logic [BASE_W-1:0] SPAN = MEM_HI - MEM_LO;

  logic [BASE_W-1:0] top;
  logic [BASE_W-1:0] rel;

  always_comb begin
    base_bad = entry.base[BASE_W-1];
    top      = {1'b0, entry.base[BASE_W-2:0]};
    xaddr    = {top, req_addr[OFFSET_W-1:0], {LSB_W{1'b0}}};
    rel      = top - MEM_LO;
    to_mem   = (rel <= SPAN);
  end
endmodule

// File: rtl/pae_out_stage.sv
module pae_out_stage #(
  parameter int OUT_W  = 32,
  parameter int ATTR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_write,
  input  logic [OUT_W-1:0]  in_addr,
  input  logic              in_to_mem,
  input  logic [ATTR_W-1:0] in_attr,
  input  logic              in_bad,
  output logic              out_valid,
  output logic              out_write,
  output logic [OUT_W-1:0]  out_addr,
  output logic              out_to_mem,
  output logic [ATTR_W-1:0] out_attr,
  output logic              err_flag
);
  logic err_d;
  logic load_en;

  always_comb begin
    load_en = in_valid;
    err_d   = err_flag | (in_valid & in_bad);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      err_flag  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_write  <= 1'b0;
      out_addr   <= '0;
      out_to_mem <= 1'b0;
      out_attr   <= '0;
    end else if (load_en) begin
      out_write  <= in_write;
      out_addr   <= in_addr;
      out_to_mem <= in_to_mem;
      out_attr   <= in_attr;
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_lsb_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[2:0] == 3'b000));
  assert_top_bit_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_addr[OUT_W-1] == 1'b0);
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_addr) && $stable(out_attr));
endmodule

// File: rtl/pae_addr_ext.sv
module pae_addr_ext
  import pae_pkg::*;
#(
  parameter int                ADDR_IN_W = 24,
  parameter int                OUT_W     = 32,
  parameter int                PAGE_BITS = 3,
  parameter logic [BASE_W-1:0] MEM_LO    = 8'h00,
  parameter logic [BASE_W-1:0] MEM_HI    = 8'h3F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [PAGE_BITS-1:0] cfg_idx,
  input  logic [BASE_W-1:0]    cfg_base,
  input  logic [ATTR_W-1:0]    cfg_attr,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_IN_W-1:0] req_addr,
  output logic                 out_valid,
  output logic                 out_write,
  output logic [OUT_W-1:0]     out_addr,
  output logic                 out_to_mem,
  output logic [ATTR_W-1:0]    out_attr,
  output logic                 err_flag
);
  page_entry_t          sel_entry;
  logic [OUT_W-1:0]     x_addr;
  logic                 x_to_mem;
  logic                 x_bad;

  pae_page_regs #(.PAGE_BITS(PAGE_BITS)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_base(cfg_base), .wr_attr(cfg_attr),
    .rd_idx(req_addr[ADDR_IN_W-1 -: PAGE_BITS]), .rd_entry(sel_entry)
  );

  pae_xlate #(
    .ADDR_IN_W(ADDR_IN_W), .OUT_W(OUT_W), .PAGE_BITS(PAGE_BITS),
    .MEM_LO(MEM_LO), .MEM_HI(MEM_HI)
  ) i_xlate (
    .req_addr(req_addr), .entry(sel_entry),
    .xaddr(x_addr), .to_mem(x_to_mem), .base_bad(x_bad)
  );

  pae_out_stage #(.OUT_W(OUT_W), .ATTR_W(ATTR_W)) i_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_write(req_write), .in_addr(x_addr),
    .in_to_mem(x_to_mem), .in_attr(sel_entry.attr), .in_bad(x_bad),
    .out_valid(out_valid), .out_write(out_write), .out_addr(out_addr),
    .out_to_mem(out_to_mem), .out_attr(out_attr), .err_flag(err_flag)
  );
endmodule

// File: tb/test_pae_addr_ext.sv
module test_pae_addr_ext;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [7:0]  cfg_base;
  logic [1:0]  cfg_attr;
  logic        req_valid;
  logic        req_write;
  logic [23:0] req_addr;
  logic        out_valid, out_write, out_to_mem, err_flag;
  logic [31:0] out_addr;
  logic [1:0]  out_attr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit run    = 1'b0;
  bit done   = 1'b0;

  // reference model state
  int          m_base [8];
  int          m_attr [8];
  logic        e_valid, e_write, e_mem, e_err;
  logic [31:0] e_addr;
  logic [1:0]  e_attr;

  pae_addr_ext i_pae_addr_ext (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_attr(cfg_attr), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .out_valid(out_valid),
    .out_write(out_write), .out_addr(out_addr), .out_to_mem(out_to_mem),
    .out_attr(out_attr), .err_flag(err_flag)
  );

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin m_base[k] = k; m_attr[k] = 0; end
      e_valid = 0; e_write = 0; e_mem = 0; e_err = 0; e_addr = 0; e_attr = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        int pg, top;
        pg = req_addr / (1 << 21);
        top = m_base[pg] % 128;
        e_addr  = top * (1 << 24) + (req_addr % (1 << 21)) * 8;
        e_write = req_write;
        e_mem   = (top >= 0) && (top <= 63);
        e_attr  = 2'(m_attr[pg]);
        if (m_base[pg] >= 128) e_err = 1;
      end
      if (cfg_we) begin
        m_base[cfg_idx] = cfg_base;
        m_attr[cfg_idx] = cfg_attr;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && run) begin
      check("R2 valid", 32'(out_valid), 32'(e_valid));
      check("R2 write", 32'(out_write), 32'(e_write));
      check("R3 low bits", 32'(out_addr[23:0]), 32'(e_addr[23:0]));
      check("R4 top byte", 32'(out_addr[31:24]), 32'(e_addr[31:24]));
      check("R5 err", 32'(err_flag), 32'(e_err));
      check("R7 target", 32'(out_to_mem), 32'(e_mem));
      check("R8 attr", 32'(out_attr), 32'(e_attr));
    end
    if (cycles > 5000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic drive(input logic v, input logic w, input logic [23:0] a,
                       input logic we, input logic [2:0] i, input logic [7:0] b,
                       input logic [1:0] at);
    req_valid = v; req_write = w; req_addr = a;
    cfg_we = we; cfg_idx = i; cfg_base = b; cfg_attr = at;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0;
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    rst_n = 1;
    drive(0, 0, 0, 0, 0, 0, 0);
    // R1 reset state
    check("R1 valid", 32'(out_valid), 0);
    check("R1 err", 32'(err_flag), 0);
    run = 1;
    // R1/R4 identity sweep over all pages
    for (int p = 0; p < 8; p++) begin
      drive(1, p[0], {p[2:0], 21'h0ABCD + 21'(p)}, 0, 0, 0, 0);
      check("R1 identity", 32'(out_addr[31:24]), 32'(p));
    end
    // R9 idle hold
    drive(0, 0, 24'hFFFFFF, 0, 0, 0, 0);
    drive(0, 1, 24'h123456, 0, 0, 0, 0);
    check("R9 hold", out_addr, {8'd7, 21'h0ABCD + 21'd7, 3'b0});
    // R7 page outside memory window
    drive(0, 0, 0, 1, 3'd2, 8'h40, 2'd3);
    drive(1, 1, {3'd2, 21'h1FFFFF}, 0, 0, 0, 0);
    check("R7 on-chip bus", 32'(out_to_mem), 0);
    check("R8 attr", 32'(out_attr), 3);
    // R6 same-cycle write uses old base
    drive(1, 0, {3'd5, 21'h000001}, 1, 3'd5, 8'h85, 2'd1);
    check("R6 old base", 32'(out_addr[31:24]), 5);
    check("R6 no err yet", 32'(err_flag), 0);
    // R5 upper-half base
    drive(1, 0, {3'd5, 21'h000002}, 0, 0, 0, 0);
    check("R5 bit31 cleared", 32'(out_addr[31:24]), 8'h05);
    check("R5 err set", 32'(err_flag), 1);
    // R5 stickiness over clean accesses
    drive(1, 0, {3'd0, 21'h000010}, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    check("R5 err sticky", 32'(err_flag), 1);
    // window edge: base 0x3F inside, 0xBF maps to 0x3F
    drive(0, 0, 0, 1, 3'd6, 8'h3F, 2'd2);
    drive(1, 0, {3'd6, 21'h0}, 0, 0, 0, 0);
    check("R7 window edge", 32'(out_to_mem), 1);
    drive(1, 1, {3'd3, 21'h155555}, 1, 3'd3, 8'h7F, 2'd0);
    drive(1, 1, {3'd3, 21'h0AAAAA}, 0, 0, 0, 0);
    check("R4 top byte", 32'(out_addr[31:24]), 8'h7F);
    drive(0, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule